// File: doc/BRIEF.md
# Predictive L0 Instruction Cache Bypass

This block is a small direct-mapped instruction buffer. It sits between an instruction fetch stage and a larger second-level instruction cache, here called the L1. A one-bit next-fetch predictor decides, for each accepted fetch, one of two paths. On the first path the fetch probes the L0 data array. On the second path the fetch goes straight to the L1 and the L0 data array is not read. Fetches that are likely to miss therefore skip the serial L0-then-L1 path and its extra cycle. Fetches that are likely to hit stay in the small array.

The L0 tags are kept apart from the L0 data. The tags are compared on every fetch, including fetches sent directly to the L1. That comparison trains the predictor: a tag hit points the following fetch at the L0, and a tag miss points it at the L1. Any fetch whose tag compare misses writes the returned L1 line into the L0. Four event counters expose probe hits, probe misses, bypassed fetches and bypassed fetches whose tag compare hit, so predictor accuracy can be measured from outside.

Addresses are word addresses. The low `log2(WORDS)` bits select a word in a line, the next `log2(LINES)` bits select the line, and the remaining upper bits form the tag. The L1 receives a one-cycle request pulse carrying the line-aligned word address. After its own fixed latency it returns the whole line together with a one-cycle valid.

Top module: `l0_bypass_icache`

## Requirements
- R1: When a fetch probes the L0 and the tag matches, `fetch_rsp_valid` is high in the cycle after acceptance with the addressed word, and no L1 request is issued for that fetch.
- R2: After a fetch whose tag compare hits, the next fetch probes the L0, so if its line is present it completes one cycle after acceptance.
- R3: After a fetch whose tag compare misses, the next fetch bypasses the L0 data array and issues its L1 request in the cycle after acceptance, even when its line is present.
- R4: The tag compare also runs on bypassed fetches; a bypassed fetch whose tag matches increments `cnt_bypass_tag_hit` and points the following fetch at the L0.
- R5: Every fetch whose tag compare misses writes the returned L1 line into the L0 and marks it valid, whether or not the L0 was bypassed; later fetches to any word of that line can hit.
- R6: After reset all L0 lines are invalid, all counters read zero, `fetch_ready` is high, and the first fetch is bypassed to the L1.
- R7: A bypassed fetch raises `l1_req_valid` in the first cycle after acceptance, while a probe that misses raises it in the second cycle. Either fetch responds in the cycle `l1_rsp_valid` is high, so the mispredicted path costs exactly one cycle more than the bypass path. `l1_req_valid` is a single-cycle pulse.
- R8: `fetch_ready` is low from the cycle after acceptance through the response cycle, including all cycles with an L1 request outstanding, and is high again in the cycle after the response.
- R9: Word offset is `fetch_addr[OFF_W-1:0]`, the line index is the next `IDX_W` bits, and the tag is the rest. `l1_req_addr` equals the fetch address with the offset bits cleared, and a fetch with the same index but a different tag evicts the resident line.
- R10: `cnt_l0_hit` and `cnt_l0_miss` count probes that hit and miss, and `cnt_bypass` counts bypassed fetches. Each counter steps by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | ADDR_W | Fetch word address |
| fetch_ready | output | 1 | Block can accept a fetch |
| fetch_rsp_valid | output | 1 | Instruction word returned this cycle |
| fetch_rsp_data | output | DATA_W | Returned instruction word |
| l1_req_valid | output | 1 | One-cycle L1 line request |
| l1_req_addr | output | ADDR_W | Line-aligned word address to L1 |
| l1_rsp_valid | input | 1 | L1 line returned this cycle |
| l1_rsp_line | input | WORDS*DATA_W | Returned line, word 0 in the low bits |
| cnt_l0_hit | output | CNT_W | Probes that hit |
| cnt_l0_miss | output | CNT_W | Probes that missed |
| cnt_bypass | output | CNT_W | Fetches that skipped the L0 data array |
| cnt_bypass_tag_hit | output | CNT_W | Bypassed fetches whose tag compare hit |

## Verification
The hardest state to reach is a bypassed fetch whose line is already resident. It needs a line that was just filled, followed directly by a fetch to a neighbouring word of that line. The reverse case is also hard: a probe that misses needs a hit immediately before a fetch to a new or evicted line. The directed sequences walk through one line word by word after a cold miss, then jump to a fresh index, and then alias a second tag onto index zero. This makes the predictor pass through every transition. A reference model in the bench tracks valid bits, tags and the predicted path, and it predicts each latency, each L1 request and each counter value.

// File: rtl/l0bp_pkg.sv
package l0bp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_REQ   = 2'd2,
    ST_WAIT  = 2'd3
  } l0bp_state_e;

  localparam int unsigned EV_L0_HIT     = 0;
  localparam int unsigned EV_L0_MISS    = 1;
  localparam int unsigned EV_BYPASS     = 2;
  localparam int unsigned EV_BYPASS_HIT = 3;
  localparam int unsigned EV_COUNT      = 4;
endpackage

// File: rtl/l0bp_tag_store.sv
module l0bp_tag_store #(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAG_W = 26,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             wr_en,
  output logic             tag_hit
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx] <= tag;
  end

  assign tag_hit = valid_q[idx] && (tag_q[idx] == tag);
endmodule

// File: rtl/l0bp_data_store.sv
module l0bp_data_store #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  output logic [DATA_W-1:0] rd_word
);
  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[idx] <= wr_line;
  end

  assign rd_word = line_q[idx][off*DATA_W +: DATA_W];
endmodule

// File: rtl/l0bp_counters.sv
module l0bp_counters #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     inc,
  output logic [CNT_W-1:0] cnt [N]
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (inc[i]) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign cnt[i] = cnt_q;
  end
endmodule

// File: rtl/l0bp_fetch_ctrl.sv
module l0bp_fetch_ctrl
  import l0bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic                tag_hit,
  input  logic                l1_rsp_valid,
  output logic                fetch_ready,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                cmp_en,
  output logic                probe_en,
  output logic                l1_req_valid,
  output logic                rsp_l0,
  output logic                rsp_l1,
  output logic                fill_en,
  output logic                pred_l0,
  output logic [EV_COUNT-1:0] ev
);
  l0bp_state_e       state_q, state_d;
  logic              pred_q, pred_d;
  logic              bypass_q, bypass_d;
  logic              miss_q, miss_d;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    state_d      = state_q;
    pred_d       = pred_q;
    bypass_d     = bypass_q;
    miss_d       = miss_q;
    addr_en      = 1'b0;
    fetch_ready  = 1'b0;
    cmp_en       = 1'b0;
    probe_en     = 1'b0;
    l1_req_valid = 1'b0;
    rsp_l0       = 1'b0;
    rsp_l1       = 1'b0;
    fill_en      = 1'b0;
    ev           = '0;
    unique case (state_q)
      ST_IDLE: begin
        fetch_ready = 1'b1;
        if (fetch_valid) begin
          addr_en  = 1'b1;
          bypass_d = !pred_q;
          miss_d   = 1'b0;
          state_d  = pred_q ? ST_PROBE : ST_REQ;
        end
      end
      ST_PROBE: begin
        probe_en = 1'b1;
        cmp_en   = 1'b1;
        pred_d   = tag_hit;
        if (tag_hit) begin
          rsp_l0            = 1'b1;
          ev[EV_L0_HIT]     = 1'b1;
          state_d           = ST_IDLE;
        end else begin
          ev[EV_L0_MISS]    = 1'b1;
          miss_d            = 1'b1;
          state_d           = ST_REQ;
        end
      end
      ST_REQ: begin
        l1_req_valid = 1'b1;
        if (bypass_q) begin
          cmp_en             = 1'b1;
          pred_d             = tag_hit;
          miss_d             = !tag_hit;
          ev[EV_BYPASS]      = 1'b1;
          ev[EV_BYPASS_HIT]  = tag_hit;
        end
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (l1_rsp_valid) begin
          rsp_l1  = 1'b1;
          fill_en = miss_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pred_q   <= 1'b0;
      bypass_q <= 1'b0;
      miss_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pred_q   <= pred_d;
      bypass_q <= bypass_d;
      miss_q   <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= fetch_addr;
  end

  assign cur_addr = addr_q;
  assign pred_l0  = pred_q;
endmodule

// File: rtl/l0_bypass_icache.sv
module l0_bypass_icache
  import l0bp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              fetch_rsp_valid,
  output logic [DATA_W-1:0] fetch_rsp_data,
  output logic              l1_req_valid,
  output logic [ADDR_W-1:0] l1_req_addr,
  input  logic              l1_rsp_valid,
  input  logic [LINE_W-1:0] l1_rsp_line,
  output logic [CNT_W-1:0]  cnt_l0_hit,
  output logic [CNT_W-1:0]  cnt_l0_miss,
  output logic [CNT_W-1:0]  cnt_bypass,
  output logic [CNT_W-1:0]  cnt_bypass_tag_hit
);
  logic [ADDR_W-1:0]   cur_addr;
  logic [OFF_W-1:0]    cur_off;
  logic [IDX_W-1:0]    cur_idx;
  logic [TAG_W-1:0]    cur_tag;
  logic                tag_hit, cmp_en, probe_en, pred_l0;
  logic                rsp_l0, rsp_l1, fill_en;
  logic [EV_COUNT-1:0] ev;
  logic [DATA_W-1:0]   l0_word, l1_word;
  logic [CNT_W-1:0]    cnt [EV_COUNT];

  assign cur_off = cur_addr[OFF_W-1:0];
  assign cur_idx = cur_addr[OFF_W +: IDX_W];
  assign cur_tag = cur_addr[ADDR_W-1:OFF_W+IDX_W];

  l0bp_fetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rst_n, .fetch_valid, .fetch_addr, .tag_hit, .l1_rsp_valid,
    .fetch_ready, .cur_addr, .cmp_en, .probe_en, .l1_req_valid,
    .rsp_l0, .rsp_l1, .fill_en, .pred_l0, .ev
  );

  l0bp_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx(cur_idx), .tag(cur_tag), .wr_en(fill_en), .tag_hit
  );

  l0bp_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk, .idx(cur_idx), .off(cur_off), .wr_en(fill_en),
    .wr_line(l1_rsp_line), .rd_word(l0_word)
  );

  l0bp_counters #(.N(EV_COUNT), .CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .inc(ev), .cnt
  );

  assign l1_word         = l1_rsp_line[cur_off*DATA_W +: DATA_W];
  assign fetch_rsp_valid = rsp_l0 | rsp_l1;
  assign fetch_rsp_data  = rsp_l0 ? l0_word : l1_word;
  assign l1_req_addr     = {cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign cnt_l0_hit         = cnt[EV_L0_HIT];
  assign cnt_l0_miss        = cnt[EV_L0_MISS];
  assign cnt_bypass         = cnt[EV_BYPASS];
  assign cnt_bypass_tag_hit = cnt[EV_BYPASS_HIT];
endmodule

// File: rtl/l0bp_checker.sv
module l0bp_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_ready,
  input logic             fetch_rsp_valid,
  input logic             l1_req_valid,
  input logic             l1_rsp_valid,
  input logic             cmp_en,
  input logic             probe_en,
  input logic             tag_hit,
  input logic             pred_l0,
  input logic [CNT_W-1:0] cnt_l0_hit,
  input logic [CNT_W-1:0] cnt_bypass
);
  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outstanding_q <= 1'b0;
    else if (l1_rsp_valid) outstanding_q <= 1'b0;
    else if (l1_req_valid) outstanding_q <= 1'b1;
  end

  p_ready_low_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding_q || l1_req_valid) |-> !fetch_ready);

  p_hit_skips_l1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_en && tag_hit) |-> (fetch_rsp_valid && !l1_req_valid));

  p_pred_after_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && tag_hit) |=> pred_l0);

  p_pred_after_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !tag_hit) |=> !pred_l0);

  p_req_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid |=> !l1_req_valid);

  p_hit_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_l0_hit == $past(cnt_l0_hit)) || (cnt_l0_hit == $past(cnt_l0_hit) + CNT_W'(1)));

  p_bypass_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_bypass == $past(cnt_bypass)) || (cnt_bypass == $past(cnt_bypass) + CNT_W'(1)));
endmodule

bind l0_bypass_icache l0bp_checker #(.CNT_W(CNT_W)) u_l0bp_checker (
  .clk(clk),
  .rst_n(rst_n),
  .fetch_ready(fetch_ready),
  .fetch_rsp_valid(fetch_rsp_valid),
  .l1_req_valid(l1_req_valid),
  .l1_rsp_valid(l1_rsp_valid),
  .cmp_en(cmp_en),
  .probe_en(probe_en),
  .tag_hit(tag_hit),
  .pred_l0(pred_l0),
  .cnt_l0_hit(cnt_l0_hit),
  .cnt_bypass(cnt_bypass)
);

// File: tb/l0_bypass_icache_tb_top.sv
`timescale 1ns/1ps
module l0_bypass_icache_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LINES  = 16;
  localparam int unsigned WORDS  = 4;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned OFF_W  = 2;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned LAT    = 3;

  logic clk, rst_n;
  logic fetch_valid, fetch_ready, fetch_rsp_valid;
  logic [ADDR_W-1:0] fetch_addr, l1_req_addr;
  logic [DATA_W-1:0] fetch_rsp_data;
  logic l1_req_valid, l1_rsp_valid;
  logic [WORDS*DATA_W-1:0] l1_rsp_line;
  logic [CNT_W-1:0] cnt_l0_hit, cnt_l0_miss, cnt_bypass, cnt_bypass_tag_hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  l0_bypass_icache dut_i (
    .clk, .rst_n, .fetch_valid, .fetch_addr, .fetch_ready,
    .fetch_rsp_valid, .fetch_rsp_data, .l1_req_valid, .l1_req_addr,
    .l1_rsp_valid, .l1_rsp_line, .cnt_l0_hit, .cnt_l0_miss,
    .cnt_bypass, .cnt_bypass_tag_hit
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {a[15:0], a[15:0] ^ 16'hC3A5};
  endfunction

  // L1 model: request seen in cycle c, line returned in cycle c+LAT
  logic              l1_pend;
  int                l1_cnt;
  int                l1_reqs;
  logic [ADDR_W-1:0] l1_last_addr;

  initial begin
    l1_pend = 1'b0; l1_cnt = 0; l1_reqs = 0; l1_last_addr = '0;
    l1_rsp_valid = 1'b0; l1_rsp_line = '0;
  end

  always @(negedge clk) begin
    l1_rsp_valid <= 1'b0;
    if (l1_pend) begin
      if (l1_cnt == 1) begin
        l1_rsp_valid <= 1'b1;
        for (int w = 0; w < WORDS; w++)
          l1_rsp_line[w*DATA_W +: DATA_W] <= word_of(l1_last_addr | ADDR_W'(w));
        l1_pend <= 1'b0;
      end else begin
        l1_cnt <= l1_cnt - 1;
      end
    end else if (l1_req_valid) begin
      l1_pend      <= 1'b1;
      l1_cnt       <= LAT;
      l1_last_addr <= l1_req_addr;
      l1_reqs      <= l1_reqs + 1;
    end
  end

  // reference model built from the requirements
  bit                        m_valid [LINES];
  logic [ADDR_W-1:0]         m_tag   [LINES];
  bit                        m_pred;
  int e_hit, e_miss, e_byp, e_byp_hit;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [ADDR_W-1:0] a, input string req);
    int idx, lat, reqs0, exp_lat, exp_reqs;
    bit hitm, ready_bad;
    logic [DATA_W-1:0] got;
    logic [ADDR_W-1:0] tg;
    idx  = int'(a[OFF_W +: IDX_W]);
    tg   = a >> (OFF_W + IDX_W);
    hitm = m_valid[idx] && (m_tag[idx] == tg);
    if (m_pred) begin
      exp_lat  = hitm ? 1 : 2 + LAT;
      exp_reqs = hitm ? 0 : 1;
      if (hitm) e_hit++; else e_miss++;
    end else begin
      exp_lat  = 1 + LAT;
      exp_reqs = 1;
      e_byp++;
      if (hitm) e_byp_hit++;
    end
    if (!hitm) begin m_valid[idx] = 1; m_tag[idx] = tg; end
    m_pred = hitm;

    for (int k = 0; k < 50; k++) begin
      @(negedge clk); #1;
      if (fetch_ready) break;
    end
    chk(fetch_ready, "R8", "ready before fetch", fetch_ready, 1);
    reqs0 = l1_reqs;
    fetch_valid = 1'b1; fetch_addr = a;
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    lat = 0; ready_bad = 0; got = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      lat++;
      if (fetch_ready) ready_bad = 1;
      if (fetch_rsp_valid) begin got = fetch_rsp_data; break; end
    end
    chk(lat == exp_lat, req, "fetch latency", lat, exp_lat);
    chk(got == word_of(a), req, "fetch data", got, word_of(a));
    chk(!ready_bad, "R8", "ready low while busy", ready_bad, 0);
    @(negedge clk); #1;
    chk(fetch_ready, "R8", "ready after response", fetch_ready, 1);
    chk(l1_reqs - reqs0 == exp_reqs, req, "L1 request count", l1_reqs - reqs0, exp_reqs);
    if (exp_reqs == 1)
      chk(l1_last_addr == {a[ADDR_W-1:OFF_W], 2'b00}, "R9", "L1 line address",
          l1_last_addr, {a[ADDR_W-1:OFF_W], 2'b00});
  endtask

  task automatic check_counters(input string req);
    chk(cnt_l0_hit == CNT_W'(e_hit), req, "cnt_l0_hit", cnt_l0_hit, e_hit);
    chk(cnt_l0_miss == CNT_W'(e_miss), req, "cnt_l0_miss", cnt_l0_miss, e_miss);
    chk(cnt_bypass == CNT_W'(e_byp), req, "cnt_bypass", cnt_bypass, e_byp);
    chk(cnt_bypass_tag_hit == CNT_W'(e_byp_hit), "R4", "cnt_bypass_tag_hit",
        cnt_bypass_tag_hit, e_byp_hit);
  endtask

  // R6: state straight after reset
  task automatic t_reset();
    @(negedge clk); #1;
    chk(fetch_ready, "R6", "ready after reset", fetch_ready, 1);
    chk(!l1_req_valid, "R6", "no L1 request after reset", l1_req_valid, 0);
    chk(!fetch_rsp_valid, "R6", "no response after reset", fetch_rsp_valid, 0);
    check_counters("R6");
  endtask

  // cold miss, then a bypassed tag hit, then probe hits on the same line
  task automatic t_cold_line();
    do_fetch(32'h0000_0100, "R6");
    do_fetch(32'h0000_0101, "R4");
    chk(cnt_bypass_tag_hit == CNT_W'(1), "R4", "bypass tag hit counted",
        cnt_bypass_tag_hit, 1);
    do_fetch(32'h0000_0102, "R5");
    do_fetch(32'h0000_0103, "R1");
    check_counters("R10");
  endtask

  // probe to a fresh line after a hit, then predictor points to L1
  task automatic t_mispredict();
    do_fetch(32'h0000_0204, "R7");
    do_fetch(32'h0000_0205, "R3");
    do_fetch(32'h0000_0206, "R2");
    check_counters("R10");
  endtask

  // second tag on index 0 evicts the first line
  task automatic t_conflict();
    do_fetch(32'h0000_0140, "R9");
    do_fetch(32'h0000_0101, "R9");
    do_fetch(32'h0000_0102, "R5");
    do_fetch(32'h0000_0100, "R1");
    do_fetch(32'h0000_0143, "R7");
    check_counters("R10");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
    m_pred = 0; e_hit = 0; e_miss = 0; e_byp = 0; e_byp_hit = 0;
    fetch_valid = 1'b0; fetch_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_line();
    t_mispredict();
    t_conflict();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule